// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps the time of day and the calendar date for a system that has a slow periodic enable available, such as a 64 Hz strobe divided down from a watch crystal. A prescaler counts `TICKS_PER_SEC` sub-second strobes and produces one second step. That step ripples through seconds, minutes and hours, then advances the day of month, the day of week, the month and a two-digit year.

Seconds, minutes, hours, day of month and year are held as two BCD digits each. The month is a plain binary number from 1 to 12. The day of week is a binary 0 to 6. Month lengths are applied automatically. February gets 29 days in every year whose two-digit value divides by four.

Software sets the clock through a parallel load port. A load stops the clock until a separate run strobe releases it. A level hold input freezes counting at any time. Reading is done by a capture strobe, which copies the live counters into a registered read port. That read port keeps its value until the next capture, so a multi-field read is always coherent.

Top module: `bcd_clock_calendar`

## Requirements
- R1: After reset the read port and the live counters show 00:00:00, day 01, month 1, year 00, day of week 0, and the counters are running.
- R2: Seconds count BCD 00..59 and minutes count BCD 00..59. Each wraps to 00 and carries into the next field. Each nibble is a decimal digit 0..9, with the tens digit in bits [7:4] and the units digit in bits [3:0].
- R3: Hours count BCD 00..23 in 24-hour form. The wrap from 23 to 00 advances the date.
- R4: The day of month counts from BCD 01. It rolls over to 01 and advances the month after 31 in months 1, 3, 5, 7, 8, 10 and 12, and after 30 in months 4, 6, 9 and 11.
- R5: In month 2 the day rolls over after 29 when the BCD year value is a multiple of four (00 included), and after 28 otherwise.
- R6: The month is binary 1..12 and wraps from 12 to 1. That wrap increments the BCD year, which wraps from 99 to 00.
- R7: The day of week is binary 0..6. It advances whenever the day of month advances and wraps from 6 to 0.
- R8: A set strobe loads all seven fields and clears the prescaler. The clock then stays stopped until a run strobe arrives. If set and run occur in the same cycle, set wins and the clock stays stopped.
- R9: While hold is high, sub-second strobes are ignored and no field changes.
- R10: While running, one second is added on the clock edge that receives the `TICKS_PER_SEC`-th counted sub-second strobe. After a load, the first second needs a full count.
- R11: A capture strobe copies the live fields, as they stand before that edge's update, into the read port on that edge. Without a capture the read port does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sub_tick_i | input | 1 | Sub-second enable strobe, one cycle per pulse |
| hold_i | input | 1 | Level; freezes prescaler and counters while high |
| set_i | input | 1 | Load strobe; loads all fields and stops the clock |
| run_i | input | 1 | Release strobe; restarts a stopped clock |
| set_sec_i | input | 8 | BCD seconds to load |
| set_min_i | input | 8 | BCD minutes to load |
| set_hour_i | input | 8 | BCD hours to load |
| set_day_i | input | 8 | BCD day of month to load |
| set_wday_i | input | 3 | Day of week to load, 0..6 |
| set_month_i | input | 4 | Binary month to load, 1..12 |
| set_year_i | input | 8 | BCD year to load |
| capture_i | input | 1 | Capture strobe for the read port |
| rd_sec_o | output | 8 | Captured BCD seconds |
| rd_min_o | output | 8 | Captured BCD minutes |
| rd_hour_o | output | 8 | Captured BCD hours |
| rd_day_o | output | 8 | Captured BCD day of month |
| rd_wday_o | output | 3 | Captured day of week |
| rd_month_o | output | 4 | Captured binary month |
| rd_year_o | output | 8 | Captured BCD year |

## Verification
The whole carry chain, from the second step through to the year, settles on the same rising edge that takes the final sub-second strobe of a second. A capture placed after that edge shows the result on the read port one edge later. The bench drives every strobe on a falling edge and raises capture only after the last sub-tick has been taken. It then compares the read port at the next falling edge, which is one full edge after the capture was registered. The checks for hold, stop and an unfinished prescaler count sample the read port once a full second's worth of strobes has gone by, so any step that should not have happened would have had time to appear.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

  localparam int BCD_W  = 8;
  localparam int MON_W  = 4;
  localparam int WDAY_W = 3;

  typedef struct packed {
    logic [BCD_W-1:0]  year;
    logic [MON_W-1:0]  month;
    logic [WDAY_W-1:0] wday;
    logic [BCD_W-1:0]  day;
    logic [BCD_W-1:0]  hour;
    logic [BCD_W-1:0]  min;
    logic [BCD_W-1:0]  sec;
  } cal_t;

  localparam cal_t CAL_RESET = '{year: 8'h00, month: 4'd1, wday: 3'd0,
                                 day: 8'h01, hour: 8'h00, min: 8'h00,
                                 sec: 8'h00};

  // two-digit BCD increment, no wrap handling
  function automatic logic [BCD_W-1:0] bcd_inc(input logic [BCD_W-1:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // 10*t + u is a multiple of 4 exactly when 2*t + u is
  function automatic logic bcd_year_leap(input logic [BCD_W-1:0] y);
    logic [3:0] s;
    s = {y[6:4], 1'b0} + y[3:0];
    return (s[1:0] == 2'b00);
  endfunction

  function automatic logic [BCD_W-1:0] bcd_month_last(input logic [MON_W-1:0] m,
                                                      input logic [BCD_W-1:0] y);
    case (m)
      4'd2:                      return bcd_year_leap(y) ? 8'h29 : 8'h28;
      4'd4, 4'd6, 4'd9, 4'd11:   return 8'h30;
      default:                   return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/bcd_cal_prescaler.sv
module bcd_cal_prescaler #(
  parameter int TICKS_PER_SEC = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic run_i,
  input  logic sub_tick_i,
  output logic sec_pulse_o
);
  localparam int W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [W-1:0] LAST = W'(TICKS_PER_SEC - 1);

  logic [W-1:0] cnt_q;

  assign sec_pulse_o = run_i && sub_tick_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      cnt_q <= '0;
    end else if (run_i && sub_tick_i) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  // R8: a load restarts the sub-second count from zero
  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (cnt_q == '0));

  // R9: without run the sub-second count is frozen
  p_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !clear_i) |=> $stable(cnt_q));

endmodule

// File: rtl/bcd2_counter.sv
module bcd2_counter
  import bcd_cal_pkg::*;
#(
  parameter logic [BCD_W-1:0] FIRST = 8'h00
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_i,
  input  logic [BCD_W-1:0] ld_val_i,
  input  logic             inc_i,
  input  logic [BCD_W-1:0] last_i,
  output logic [BCD_W-1:0] val_o,
  output logic             carry_o
);
  logic [BCD_W-1:0] val_q;

  assign val_o   = val_q;
  assign carry_o = inc_i && (val_q == last_i);

  always_ff @(posedge clk) begin
    if (rst)          val_q <= FIRST;
    else if (ld_i)    val_q <= ld_val_i;
    else if (inc_i)   val_q <= (val_q == last_i) ? FIRST : bcd_inc(val_q);
  end

  // R2: both nibbles stay decimal digits
  p_digits_r2: assert property (@(posedge clk) disable iff (rst)
    (val_q[3:0] <= 4'd9) && (val_q[7:4] <= 4'd9));

  // R2: stepping past the last value returns to the first
  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !ld_i && (val_q == last_i)) |=> (val_q == FIRST));

endmodule

// File: rtl/bcd_cal_date.sv
module bcd_cal_date
  import bcd_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_i,
  input  logic [BCD_W-1:0]  ld_day_i,
  input  logic [WDAY_W-1:0] ld_wday_i,
  input  logic [MON_W-1:0]  ld_month_i,
  input  logic [BCD_W-1:0]  ld_year_i,
  input  logic              day_inc_i,
  output logic [BCD_W-1:0]  day_o,
  output logic [WDAY_W-1:0] wday_o,
  output logic [MON_W-1:0]  month_o,
  output logic [BCD_W-1:0]  year_o
);
  localparam logic [WDAY_W-1:0] WDAY_LAST = WDAY_W'(6);
  localparam logic [MON_W-1:0]  MON_LAST  = MON_W'(12);

  logic [MON_W-1:0]  month_q;
  logic [BCD_W-1:0]  year_q;
  logic [WDAY_W-1:0] wday_q;
  logic [BCD_W-1:0]  day_last;
  logic              mon_inc;

  assign day_last = bcd_month_last(month_q, year_q);

  bcd2_counter #(.FIRST(8'h01)) day_cnt_i (
    .clk      (clk),
    .rst      (rst),
    .ld_i     (ld_i),
    .ld_val_i (ld_day_i),
    .inc_i    (day_inc_i),
    .last_i   (day_last),
    .val_o    (day_o),
    .carry_o  (mon_inc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      month_q <= CAL_RESET.month;
      year_q  <= CAL_RESET.year;
      wday_q  <= CAL_RESET.wday;
    end else if (ld_i) begin
      month_q <= ld_month_i;
      year_q  <= ld_year_i;
      wday_q  <= ld_wday_i;
    end else begin
      if (day_inc_i)
        wday_q <= (wday_q == WDAY_LAST) ? '0 : wday_q + 1'b1;
      if (mon_inc) begin
        if (month_q == MON_LAST) begin
          month_q <= MON_W'(1);
          year_q  <= (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);
        end else begin
          month_q <= month_q + 1'b1;
        end
      end
    end
  end

  assign month_o = month_q;
  assign year_o  = year_q;
  assign wday_o  = wday_q;

  // R6: month never leaves 1..12
  p_month_range_r6: assert property (@(posedge clk) disable iff (rst)
    (month_q >= MON_W'(1)) && (month_q <= MON_LAST));

  // R6: December rollover of year 99 gives year 00
  p_year_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (mon_inc && !ld_i && (month_q == MON_LAST) && (year_q == 8'h99))
      |=> (year_q == 8'h00) && (month_q == MON_W'(1)));

  // R7: day of week never leaves 0..6
  p_wday_range_r7: assert property (@(posedge clk) disable iff (rst)
    wday_q <= WDAY_LAST);

  // R5: in a leap year February 28 steps to 29
  p_leap_day_r5: assert property (@(posedge clk) disable iff (rst)
    (day_inc_i && !ld_i && (month_q == MON_W'(2)) && (day_o == 8'h28) &&
     (year_q[1:0] == 2'b00) && !year_q[4]) |=> (day_o == 8'h29));

endmodule

// File: rtl/bcd_clock_calendar.sv
module bcd_clock_calendar
  import bcd_cal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sub_tick_i,
  input  logic              hold_i,
  input  logic              set_i,
  input  logic              run_i,
  input  logic [BCD_W-1:0]  set_sec_i,
  input  logic [BCD_W-1:0]  set_min_i,
  input  logic [BCD_W-1:0]  set_hour_i,
  input  logic [BCD_W-1:0]  set_day_i,
  input  logic [WDAY_W-1:0] set_wday_i,
  input  logic [MON_W-1:0]  set_month_i,
  input  logic [BCD_W-1:0]  set_year_i,
  input  logic              capture_i,
  output logic [BCD_W-1:0]  rd_sec_o,
  output logic [BCD_W-1:0]  rd_min_o,
  output logic [BCD_W-1:0]  rd_hour_o,
  output logic [BCD_W-1:0]  rd_day_o,
  output logic [WDAY_W-1:0] rd_wday_o,
  output logic [MON_W-1:0]  rd_month_o,
  output logic [BCD_W-1:0]  rd_year_o
);
  localparam int N_TIME = 3;  // seconds, minutes, hours
  localparam logic [BCD_W-1:0] TIME_LAST [N_TIME] = '{8'h59, 8'h59, 8'h23};

  logic             stopped_q;
  logic             count_en;
  logic [N_TIME:0]  chain;
  logic [BCD_W-1:0] time_ld  [N_TIME];
  logic [BCD_W-1:0] time_val [N_TIME];
  cal_t             live;
  cal_t             rd_q;

  // stop/run control: set stops the clock, run releases it, set wins
  always_ff @(posedge clk) begin
    if (rst)        stopped_q <= 1'b0;
    else if (set_i) stopped_q <= 1'b1;
    else if (run_i) stopped_q <= 1'b0;
  end

  assign count_en = !stopped_q && !hold_i;

  bcd_cal_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) presc_i (
    .clk         (clk),
    .rst         (rst),
    .clear_i     (set_i),
    .run_i       (count_en),
    .sub_tick_i  (sub_tick_i),
    .sec_pulse_o (chain[0])
  );

  assign time_ld[0] = set_sec_i;
  assign time_ld[1] = set_min_i;
  assign time_ld[2] = set_hour_i;

  for (genvar g = 0; g < N_TIME; g++) begin : g_time
    bcd2_counter #(.FIRST(8'h00)) cnt_i (
      .clk      (clk),
      .rst      (rst),
      .ld_i     (set_i),
      .ld_val_i (time_ld[g]),
      .inc_i    (chain[g]),
      .last_i   (TIME_LAST[g]),
      .val_o    (time_val[g]),
      .carry_o  (chain[g+1])
    );
  end

  bcd_cal_date date_i (
    .clk        (clk),
    .rst        (rst),
    .ld_i       (set_i),
    .ld_day_i   (set_day_i),
    .ld_wday_i  (set_wday_i),
    .ld_month_i (set_month_i),
    .ld_year_i  (set_year_i),
    .day_inc_i  (chain[N_TIME]),
    .day_o      (live.day),
    .wday_o     (live.wday),
    .month_o    (live.month),
    .year_o     (live.year)
  );

  assign live.sec  = time_val[0];
  assign live.min  = time_val[1];
  assign live.hour = time_val[2];

  // registered read port
  always_ff @(posedge clk) begin
    if (rst)            rd_q <= CAL_RESET;
    else if (capture_i) rd_q <= live;
  end

  assign rd_sec_o   = rd_q.sec;
  assign rd_min_o   = rd_q.min;
  assign rd_hour_o  = rd_q.hour;
  assign rd_day_o   = rd_q.day;
  assign rd_wday_o  = rd_q.wday;
  assign rd_month_o = rd_q.month;
  assign rd_year_o  = rd_q.year;

  // R8: a stopped clock keeps every field
  p_stopped_r8: assert property (@(posedge clk) disable iff (rst)
    (stopped_q && !set_i) |=> $stable(live));

  // R9: hold keeps every field
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (hold_i && !set_i) |=> $stable(live));

  // R11: the read port changes only on capture, and then to the prior live value
  p_rd_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !capture_i |=> $stable(rd_q));
  p_rd_load_r11: assert property (@(posedge clk) disable iff (rst)
    capture_i |=> (rd_q == $past(live)));

endmodule

// File: tb/bcd_clock_calendar_tb_top.sv
module bcd_clock_calendar_tb_top;
  localparam int TPS = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sub_tick = 1'b0, hold = 1'b0, set_s = 1'b0, run_s = 1'b0, cap = 1'b0;
  logic [7:0] s_sec = '0, s_min = '0, s_hour = '0, s_day = 8'h01, s_year = '0;
  logic [2:0] s_wday = '0;
  logic [3:0] s_mon = 4'd1;
  logic [7:0] r_sec, r_min, r_hour, r_day, r_year;
  logic [2:0] r_wday;
  logic [3:0] r_mon;

  int checks = 0, failures = 0, cyc = 0;
  int ms, mm, mh, md, mw, mo, my;
  logic [46:0] last_exp;

  always #2.5 clk = ~clk;

  bcd_clock_calendar #(.TICKS_PER_SEC(TPS)) dut_i (
    .clk(clk), .rst(rst), .sub_tick_i(sub_tick), .hold_i(hold),
    .set_i(set_s), .run_i(run_s),
    .set_sec_i(s_sec), .set_min_i(s_min), .set_hour_i(s_hour),
    .set_day_i(s_day), .set_wday_i(s_wday), .set_month_i(s_mon),
    .set_year_i(s_year), .capture_i(cap),
    .rd_sec_o(r_sec), .rd_min_o(r_min), .rd_hour_o(r_hour),
    .rd_day_o(r_day), .rd_wday_o(r_wday), .rd_month_o(r_mon),
    .rd_year_o(r_year)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) * 16) + (v % 10));
  endfunction

  function automatic int dim(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [46:0] exp_vec();
    return {bcd(my), 4'(mo), 3'(mw), bcd(md), bcd(mh), bcd(mm), bcd(ms)};
  endfunction

  task automatic model_sec();
    ms++;
    if (ms == 60) begin
      ms = 0; mm++;
      if (mm == 60) begin
        mm = 0; mh++;
        if (mh == 24) begin
          mh = 0; mw = (mw + 1) % 7; md++;
          if (md > dim(mo, my)) begin
            md = 1; mo++;
            if (mo > 12) begin mo = 1; my = (my + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic compare(input string tag, input logic [46:0] e);
    logic [46:0] a;
    a = {r_year, r_mon, r_wday, r_day, r_hour, r_min, r_sec};
    checks++;
    if (a !== e) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  task automatic cap_check(input string tag);
    @(negedge clk) cap = 1'b1;
    @(negedge clk) cap = 1'b0;
    last_exp = exp_vec();
    compare(tag, last_exp);
  endtask

  task automatic sub_ticks(input int n);
    repeat (n) begin @(negedge clk) sub_tick = 1'b1; end
    @(negedge clk) sub_tick = 1'b0;
  endtask

  task automatic set_time(input int h, input int m, input int s, input int d,
                          input int w, input int mon, input int y, input bit with_run);
    @(negedge clk);
    s_hour = bcd(h); s_min = bcd(m); s_sec = bcd(s); s_day = bcd(d);
    s_wday = 3'(w); s_mon = 4'(mon); s_year = bcd(y);
    set_s = 1'b1; run_s = with_run;
    @(negedge clk) begin set_s = 1'b0; run_s = 1'b0; end
    mh = h; mm = m; ms = s; md = d; mw = w; mo = mon; my = y;
  endtask

  task automatic run_pulse();
    @(negedge clk) run_s = 1'b1;
    @(negedge clk) run_s = 1'b0;
  endtask

  initial begin
    int yl [6] = '{0, 1, 2, 3, 96, 99};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mh = 0; mm = 0; ms = 0; md = 1; mw = 0; mo = 1; my = 0;
    @(negedge clk);
    compare("R1 reset read port", exp_vec());
    cap_check("R1 reset live values");

    // R10: half a second does not step, the full count does
    sub_ticks(1);
    cap_check("R10 partial count");
    sub_ticks(1);
    model_sec();
    cap_check("R10 full count after reset");

    // R2 R3: long continuous run across hour, day and February end (year 03)
    set_time(22, 58, 30, 28, 5, 2, 3, 1'b0);
    run_pulse();
    for (int i = 0; i < 4000; i++) begin
      sub_ticks(TPS);
      model_sec();
      cap_check("R2 R3 continuous seconds");
    end

    // R11: read port keeps its value without capture
    sub_ticks(3 * TPS);
    @(negedge clk);
    compare("R11 no capture keeps read port", last_exp);
    for (int i = 0; i < 3; i++) model_sec();
    cap_check("R11 capture shows advanced time");

    // R4 R5 R6 R7: month-end sweep, day before last and last day
    for (int yi = 0; yi < 6; yi++) begin
      for (int m = 1; m <= 12; m++) begin
        for (int k = 0; k < 2; k++) begin
          set_time(23, 59, 59, dim(m, yl[yi]) - 1 + k, (m + yl[yi] + k) % 7,
                   m, yl[yi], 1'b0);
          run_pulse();
          sub_ticks(TPS);
          model_sec();
          if (m == 2)       cap_check("R5 R7 February end");
          else if (m == 12) cap_check("R6 R7 year end");
          else              cap_check("R4 R7 month end");
        end
      end
    end

    // R9: hold freezes everything
    set_time(10, 20, 30, 15, 3, 7, 42, 1'b0);
    run_pulse();
    @(negedge clk) hold = 1'b1;
    sub_ticks(5 * TPS);
    cap_check("R9 held clock unchanged");
    @(negedge clk) hold = 1'b0;
    sub_ticks(TPS);
    model_sec();
    cap_check("R9 release after hold");

    // R8: set stops the clock until run
    set_time(5, 6, 7, 9, 1, 11, 58, 1'b0);
    sub_ticks(3 * TPS);
    cap_check("R8 stopped after set");
    set_time(1, 2, 3, 4, 6, 5, 77, 1'b1);
    sub_ticks(2 * TPS);
    cap_check("R8 set wins over run");
    run_pulse();
    sub_ticks(TPS);
    model_sec();
    cap_check("R8 runs after run strobe");

    // R8 R10: a load discards a partial second
    sub_ticks(1);
    set_time(12, 0, 59, 30, 2, 4, 12, 1'b0);
    run_pulse();
    sub_ticks(TPS - 1);
    cap_check("R10 prescaler cleared by load");
    sub_ticks(1);
    model_sec();
    cap_check("R8 full second after load");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule